// File: doc/BRIEF.md
# Burst-Clocked Serial ADC Sampler

This block reads a serial analog-to-digital converter over a three-wire link: an active-low select, a serial clock it drives, and a data line it samples. Frames are opened by an interval timer counted in system clock cycles. Inside each frame the serial clock runs for a fixed burst of 20 periods, and outside a frame both select and clock are parked high. The sample rate is therefore set by the frame interval, and the serial clock can stay inside its permitted band even when samples are wanted far less often than the clock alone would give.

The serial clock half-period is a count of system cycles. It is clamped to a band that the integrator sets with parameters to match the converter's allowed clock range. The frame interval is clamped from below, so that every frame is followed by at least one idle serial clock period. After the frame, the captured word appears on a parallel output with a single-cycle strobe. An enable input starts and stops periodic sampling without cutting a frame short.

Top module: `adc_burst_sampler`

## Requirements
- R1: While reset is asserted, and directly after it, `cs_n` is 1, `sclk` is 1 and `sample_vld` is 0.
- R2: A frame holds `cs_n` at 0 for exactly 41*h system cycles, where h is the effective half-period. This is one h-cycle setup with `sclk` high, followed by 20 serial periods, each of h cycles low then h cycles high. The frame holds exactly 20 rising `sclk` edges, and `sclk` is never 0 while `cs_n` is 1.
- R3: The effective half-period h is `half_div` clamped to the range [HALF_MIN, HALF_MAX]. Every low and high phase of `sclk` inside a frame lasts exactly h cycles.
- R4: While `enable` stays 1, consecutive falling edges of `cs_n` are exactly max(`interval`, 43*h) system cycles apart.
- R5: `miso` is sampled at rising `sclk` edges. Edges LEAD_BITS+1 through LEAD_BITS+12 (edges 5 to 16 by default) supply the 12-bit result, most significant bit first. The values at all other edges have no effect on `sample`.
- R6: `sample_vld` is 1 for exactly one cycle, in the cycle in which `cs_n` returns to 1. `sample` then carries the result of that frame.
- R7: When `enable` goes to 0, a frame in progress completes with its strobe, and no further frame starts. `cs_n` and `sclk` then remain at 1.
- R8: The half-period is taken when a frame starts. Changing `half_div` during a frame does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| enable | input | 1 | Allows periodic frames to start |
| half_div | input | HW | Requested serial clock half-period in system cycles |
| interval | input | IW | Requested frame-start interval in system cycles |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock, parked high between frames |
| sample | output | DATA_W | Last captured result |
| sample_vld | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench sweeps `half_div` below, inside and above the clamp band, and measures every `sclk` phase and the total select-low time. A clamp that is off by one, or missing, would stretch or shorten these phases. It sets the interval one below, exactly at, and above the 43*h minimum. A design that failed to hold an early start, or that restarted the timer at the wrong edge, would show frame spacing off by a cycle or more. The converter model drives ones on the leading and trailing bits, so a capture window that is shifted or too wide corrupts the result. A final test drops `enable` and changes `half_div` mid-frame, which catches a frame being cut off, a new frame being started, or the new setting being used too early.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SETUP = 2'd1,
    FR_LOW   = 2'd2,
    FR_HIGH  = 2'd3
  } frame_st_t;
endpackage

// File: rtl/adcs_rate_ctl.sv
// Clamps the requested half-period into the permitted band and derives the
// effective frame interval (never shorter than one frame plus one idle period).
module adcs_rate_ctl #(
  parameter int HW         = 6,
  parameter int IW         = 24,
  parameter int HALF_MIN   = 13,
  parameter int HALF_MAX   = 50,
  parameter int FRAME_CLKS = 20
) (
  input  logic [HW-1:0] half_div,
  input  logic [IW-1:0] interval,
  output logic [HW-1:0] half_eff,
  output logic [IW-1:0] iv_eff
);
  // setup half + 2 halves per serial period + one idle serial period
  localparam int MIN_MULT = 2 * FRAME_CLKS + 3;
  localparam logic [HW-1:0] H_LO = HW'(HALF_MIN);
  localparam logic [HW-1:0] H_HI = HW'(HALF_MAX);

  logic [IW-1:0] min_iv;

  always_comb begin
    if (half_div < H_LO) begin
      half_eff = H_LO;
    end else if (half_div > H_HI) begin
      half_eff = H_HI;
    end else begin
      half_eff = half_div;
    end
    min_iv = IW'(MIN_MULT) * IW'(half_eff);
    iv_eff = (interval > min_iv) ? interval : min_iv;
  end
endmodule

// File: rtl/adcs_interval_timer.sv
// Counts system cycles since the last frame start; saturates when left idle.
module adcs_interval_timer #(
  parameter int IW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] iv_eff,
  output logic          due
);
  logic [IW-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q;
    if (start) begin
      tmr_d = '0;
    end else if (tmr_q != '1) begin
      tmr_d = tmr_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_d;
    end
  end

  assign due = (tmr_q >= (iv_eff - IW'(1)));

  // R4: after a start the timer has restarted from zero
  p_timer_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tmr_q == '0));
endmodule

// File: rtl/adcs_frame_engine.sv
// Sequences one select frame: setup half, then FRAME_CLKS serial periods.
module adcs_frame_engine
  import adcs_pkg::*;
#(
  parameter int HW         = 6,
  parameter int HALF_MIN   = 13,
  parameter int HALF_MAX   = 50,
  parameter int FRAME_CLKS = 20,
  localparam int EW        = $clog2(FRAME_CLKS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [HW-1:0] half_eff,
  output logic          start,
  output logic          rise_now,
  output logic [EW-1:0] rise_idx,
  output logic          done_now,
  output logic          cs_n,
  output logic          sclk
);
  localparam logic [EW-1:0] LAST_EDGE = EW'(FRAME_CLKS);

  frame_st_t     st_q, st_d;
  logic [HW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] h_q, h_d;
  logic [EW-1:0] edge_q, edge_d;
  logic          cs_q, cs_d;
  logic          sclk_q, sclk_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign rise_idx = edge_q + EW'(1);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    h_d      = h_q;
    edge_d   = edge_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    start    = 1'b0;
    rise_now = 1'b0;
    done_now = 1'b0;
    unique case (st_q)
      FR_IDLE: begin
        cs_d   = 1'b1;
        sclk_d = 1'b1;
        if (start_req) begin
          start  = 1'b1;
          st_d   = FR_SETUP;
          h_d    = half_eff;
          cnt_d  = half_eff - HW'(1);
          edge_d = '0;
          cs_d   = 1'b0;
        end
      end
      FR_SETUP: begin
        if (cnt_zero) begin
          st_d   = FR_LOW;
          sclk_d = 1'b0;
          cnt_d  = h_q - HW'(1);
        end else begin
          cnt_d = cnt_q - HW'(1);
        end
      end
      FR_LOW: begin
        if (cnt_zero) begin
          st_d     = FR_HIGH;
          sclk_d   = 1'b1;
          rise_now = 1'b1;
          edge_d   = edge_q + EW'(1);
          cnt_d    = h_q - HW'(1);
        end else begin
          cnt_d = cnt_q - HW'(1);
        end
      end
      FR_HIGH: begin
        if (cnt_zero) begin
          if (edge_q == LAST_EDGE) begin
            st_d     = FR_IDLE;
            cs_d     = 1'b1;
            done_now = 1'b1;
          end else begin
            st_d   = FR_LOW;
            sclk_d = 1'b0;
            cnt_d  = h_q - HW'(1);
          end
        end else begin
          cnt_d = cnt_q - HW'(1);
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      h_q    <= HW'(HALF_MIN);
      edge_q <= '0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      h_q    <= h_d;
      edge_q <= edge_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
    end
  end

  assign cs_n = cs_q;
  assign sclk = sclk_q;

  // R2: clock parked high whenever select is released
  p_sclk_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_q);
  // R2: rising-edge count never exceeds the burst length
  p_edges_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= LAST_EDGE);
  // R3: latched half-period always inside the band
  p_half_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q >= HW'(HALF_MIN)) && (h_q <= HW'(HALF_MAX)));
  // R8: half-period frozen for the whole frame
  p_half_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != FR_IDLE) && $past(st_q != FR_IDLE)) |-> $stable(h_q));
endmodule

// File: rtl/adcs_shift_in.sv
// Captures the data window MSB first and presents it with a one-cycle strobe.
module adcs_shift_in #(
  parameter int DATA_W     = 12,
  parameter int LEAD_BITS  = 4,
  parameter int FRAME_CLKS = 20,
  localparam int EW        = $clog2(FRAME_CLKS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_now,
  input  logic [EW-1:0]     rise_idx,
  input  logic              miso,
  input  logic              done_now,
  output logic [DATA_W-1:0] sample,
  output logic              sample_vld
);
  localparam logic [EW-1:0] FIRST_IDX = EW'(LEAD_BITS + 1);
  localparam logic [EW-1:0] LAST_IDX  = EW'(LEAD_BITS + DATA_W);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] smp_q, smp_d;
  logic              vld_q;
  logic              in_window;

  assign in_window = (rise_idx >= FIRST_IDX) && (rise_idx <= LAST_IDX);

  always_comb begin
    shreg_d = shreg_q;
    smp_d   = smp_q;
    if (rise_now && in_window) begin
      shreg_d = {shreg_q[DATA_W-2:0], miso};
    end
    if (done_now) begin
      smp_d = shreg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      smp_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      smp_q   <= smp_d;
      vld_q   <= done_now;
    end
  end

  assign sample     = smp_q;
  assign sample_vld = vld_q;

  // R6: result only changes together with the strobe
  p_sample_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(smp_q));
endmodule

// File: rtl/adc_burst_sampler.sv
module adc_burst_sampler #(
  parameter int DATA_W     = 12,
  parameter int LEAD_BITS  = 4,
  parameter int FRAME_CLKS = 20,
  parameter int HW         = 6,
  parameter int IW         = 24,
  parameter int HALF_MIN   = 13,
  parameter int HALF_MAX   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [HW-1:0]     half_div,
  input  logic [IW-1:0]     interval,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic [DATA_W-1:0] sample,
  output logic              sample_vld
);
  localparam int EW = $clog2(FRAME_CLKS + 2);

  logic [HW-1:0] half_eff;
  logic [IW-1:0] iv_eff;
  logic          due;
  logic          start;
  logic          rise_now;
  logic [EW-1:0] rise_idx;
  logic          done_now;

  adcs_rate_ctl #(
    .HW(HW), .IW(IW), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX),
    .FRAME_CLKS(FRAME_CLKS)
  ) u_rate (
    .half_div(half_div), .interval(interval),
    .half_eff(half_eff), .iv_eff(iv_eff)
  );

  adcs_interval_timer #(.IW(IW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .iv_eff(iv_eff), .due(due)
  );

  adcs_frame_engine #(
    .HW(HW), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX), .FRAME_CLKS(FRAME_CLKS)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start_req(enable && due), .half_eff(half_eff),
    .start(start), .rise_now(rise_now), .rise_idx(rise_idx),
    .done_now(done_now), .cs_n(cs_n), .sclk(sclk)
  );

  adcs_shift_in #(
    .DATA_W(DATA_W), .LEAD_BITS(LEAD_BITS), .FRAME_CLKS(FRAME_CLKS)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .rise_now(rise_now), .rise_idx(rise_idx),
    .miso(miso), .done_now(done_now), .sample(sample), .sample_vld(sample_vld)
  );

  // R6: strobe lasts one cycle
  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);
  // R6: strobe coincides with select release
  p_vld_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (cs_n && $past(!cs_n)));
  // R7: a frame only opens while enabled
  p_start_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(enable));
endmodule

// File: tb/adc_burst_sampler_bench.sv
module adc_burst_sampler_bench;
  localparam int HW = 4, IW = 16, HMIN = 2, HMAX = 5;
  localparam int FCLK = 20, LEAD = 4, DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [HW-1:0] half_div = '0;
  logic [IW-1:0] interval = '0;
  logic miso = 1'b1;
  logic cs_n, sclk, sample_vld;
  logic [DW-1:0] sample;

  always #2.5 clk = ~clk;

  adc_burst_sampler #(
    .DATA_W(DW), .LEAD_BITS(LEAD), .FRAME_CLKS(FCLK), .HW(HW), .IW(IW),
    .HALF_MIN(HMIN), .HALF_MAX(HMAX)
  ) u_adc_burst_sampler (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
    .interval(interval), .miso(miso), .cs_n(cs_n), .sclk(sclk),
    .sample(sample), .sample_vld(sample_vld)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor / converter model state
  int cyc = 0;
  int exp_h = HMIN, exp_iv = 0, frame_h = HMIN;
  bit prev_cs = 1, prev_sclk = 1, have_prev = 0, vld_next_low = 0;
  int last_fall = 0, low_len = 0, run_len = 0, phase_bad = 0;
  int rises = 0, falls = 0, frame_no = 0, vld_count = 0, cs_falls = 0;
  int idle_low_bad = 0, last_low_len = 0;
  logic [DW-1:0] cur_word = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (vld_next_low) begin
        check(sample_vld == 1'b0, "R6", "strobe width", int'(sample_vld), 0);
        vld_next_low = 0;
      end else if (sample_vld && !( !prev_cs && cs_n)) begin
        check(0, "R6", "stray strobe", 1, 0);
      end
      if (cs_n && !sclk) idle_low_bad++;
      if (prev_cs && !cs_n) begin
        cs_falls++;
        if (have_prev)
          check(cyc - last_fall == exp_iv, "R4", "frame spacing", cyc - last_fall, exp_iv);
        last_fall = cyc; have_prev = 1; frame_h = exp_h;
        low_len = 0; run_len = 0; phase_bad = 0; rises = 0; falls = 0;
        cur_word = DW'(32'h9A7 ^ (frame_no * 263));
        frame_no++;
        miso = 1'b1;
      end
      if (!cs_n) begin
        low_len++;
        if (low_len > 1 && sclk != prev_sclk) begin
          if (run_len != frame_h) phase_bad++;
          run_len = 0;
        end
        run_len++;
        if (!sclk && prev_sclk) begin
          falls++;
          if (falls >= LEAD + 1 && falls <= LEAD + DW)
            miso = cur_word[DW - 1 - (falls - LEAD - 1)];
          else
            miso = 1'b1;
        end
        if (sclk && !prev_sclk) rises++;
      end
      if (!prev_cs && cs_n) begin
        if (run_len != frame_h) phase_bad++;
        last_low_len = low_len;
        check(low_len == 41 * frame_h, "R2", "select low length", low_len, 41 * frame_h);
        check(rises == FCLK, "R2", "rising edges", rises, FCLK);
        check(phase_bad == 0, "R3", "bad phase lengths", phase_bad, 0);
        check(sample_vld == 1'b1, "R6", "strobe at release", int'(sample_vld), 1);
        check(sample == cur_word, "R5", "captured word", int'(sample), int'(cur_word));
        vld_next_low = 1;
        vld_count++;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  function automatic int clamp_h(int hd);
    return (hd < HMIN) ? HMIN : ((hd > HMAX) ? HMAX : hd);
  endfunction

  task automatic wait_idle();
    while (!cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_cfg(int hd, int iv, int nframes);
    int hc, mn, base;
    enable = 1'b0;
    wait_idle();
    hc = clamp_h(hd); mn = 43 * hc;
    half_div = HW'(hd); interval = IW'(iv);
    exp_h = hc; exp_iv = (iv > mn) ? iv : mn; have_prev = 0;
    base = vld_count;
    enable = 1'b1;
    while (vld_count < base + nframes) @(negedge clk);
    enable = 1'b0;
  endtask

  initial begin
    int base, falls0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    check(sclk == 1'b1, "R1", "sclk in reset", int'(sclk), 1);
    check(sample_vld == 1'b0, "R1", "strobe in reset", int'(sample_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b1, "R1", "idle after reset", int'({cs_n, sclk}), 3);

    // R2/R3/R5: sweep requested half-period across and beyond the band
    for (int hd = 0; hd < 8; hd++) run_cfg(hd, 0, 3);

    // R4: interval around the minimum (h = 3, minimum 129)
    run_cfg(3, 128, 3);
    run_cfg(3, 129, 3);
    run_cfg(3, 130, 3);
    run_cfg(3, 206, 3);

    // R7 and R8: drop enable and change half_div during a frame
    enable = 1'b0;
    wait_idle();
    half_div = HW'(4); interval = '0; exp_h = 4; exp_iv = 172; have_prev = 0;
    base = vld_count;
    enable = 1'b1;
    while (cs_n) @(negedge clk);
    repeat (5) @(negedge clk);
    half_div = HW'(2);
    enable = 1'b0;
    while (vld_count == base) @(negedge clk);
    check(last_low_len == 164, "R8", "frame kept latched half-period", last_low_len, 164);
    falls0 = cs_falls;
    repeat (600) @(negedge clk);
    check(cs_falls == falls0, "R7", "frames after disable", cs_falls - falls0, 0);
    check(cs_n == 1'b1 && sclk == 1'b1, "R7", "parked after disable", int'({cs_n, sclk}), 3);
    check(idle_low_bad == 0, "R2", "sclk low while deselected", idle_low_bad, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule